// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block sits in front of a DMA transfer engine and decides which of sixteen channels the engine serves next. Each channel collects triggers from two sources: a hardware request line and a software trigger strobe. It keeps up to two outstanding triggers in a small per-channel buffer, and a channel with at least one buffered trigger is reported as pending. Hardware triggers are captured whatever the state of the hardware enable. A channel becomes eligible for service when its oldest buffered trigger came from software, or when it came from hardware and the hardware enable is set.

Eligible channels are split between a high queue and a low queue by a per-channel select input. The high queue always wins. Inside the winning queue, one mode input chooses between fixed priority and round-robin. The chosen channel is held on a one-hot grant, together with a valid flag, until the engine reports that the unit of work is finished. That unit is one frame for a frame-triggered channel and one block for a block-triggered channel. When the unit finishes, one buffered trigger is consumed.

At block completion the channel's hardware enable clears itself. A channel whose oldest trigger came from software, and whose auto-initiation input is set, keeps its trigger and so starts again at once. Each enable bit has its own set and clear strobes per channel.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the grant is all zeros, valid is low, no channel is pending, and every hardware and software enable is clear.
- R2: The grant has at most one bit set, and valid is high exactly when a bit is set. When no channel is eligible and no grant is held, valid stays low and the grant stays zero.
- R3: In fixed-priority mode (rr_mode_i = 0), the lowest-numbered eligible channel of the chosen queue wins, so channel 0 beats channel 15.
- R4: When any channel with its hiq_sel_i bit set (the high queue) is eligible, a high-queue channel is granted ahead of every low-queue channel.
- R5: In round-robin mode (rr_mode_i = 1), each queue remembers the channel it granted last, in either mode. The search starts at the next higher channel number and wraps around, so every eligible channel in the queue is served before any channel is served twice.
- R6: Each channel holds at most two outstanding triggers. A trigger that arrives while two are held is dropped, and each finished unit of work consumes exactly one trigger.
- R7: A hardware request is captured and shown on pending_o even while the channel's hardware enable is clear. The channel is granted once the enable is set, with no other action needed.
- R8: A block_done_i strobe during a grant clears the hardware enable of the granted channel.
- R9: When block_done_i arrives for a channel whose auto_init_i bit is set and whose oldest trigger came from software, the trigger is not consumed and the channel is eligible again at once. Under fixed priority this lets it hold out lower-priority channels.
- R10: A grant is held, unchanged, until the unit of work ends. The unit ends on block_done_i, or on frame_done_i when the granted channel's frame_trig_i bit is set; frame_done_i has no effect on a channel whose frame_trig_i bit is clear. A new grant appears in the second cycle after the unit ends.
- R11: A software trigger on a channel whose software enable is clear is ignored, and the channel does not become pending.
- R12: The enable set and clear strobes change only the channels whose bits are set in them. When set and clear reach the same channel in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_i | input | 16 | Hardware request per channel; each cycle it is high counts as one trigger |
| sw_trig_i | input | 16 | Software trigger strobe per channel |
| hw_en_set_i | input | 16 | Set strobe for the hardware enables |
| hw_en_clr_i | input | 16 | Clear strobe for the hardware enables |
| sw_en_set_i | input | 16 | Set strobe for the software enables |
| sw_en_clr_i | input | 16 | Clear strobe for the software enables |
| hiq_sel_i | input | 16 | 1 places the channel in the high queue, 0 in the low queue |
| rr_mode_i | input | 1 | 0 selects fixed priority, 1 selects round-robin, for both queues |
| auto_init_i | input | 16 | Auto-initiation per channel |
| frame_trig_i | input | 16 | 1 means one trigger covers one frame, 0 means one trigger covers one block |
| frame_done_i | input | 1 | Engine strobe: the current frame of the granted channel is finished |
| block_done_i | input | 1 | Engine strobe: the current block of the granted channel is finished |
| grant_o | output | 16 | One-hot grant to the engine |
| grant_valid_o | output | 1 | Grant is valid |
| pending_o | output | 16 | Channel holds at least one trigger |
| hw_en_o | output | 16 | Current hardware enables |
| sw_en_o | output | 16 | Current software enables |

## Verification
The bench checks that a corrupted trigger count or trigger-source record shows up at the ports. It appears within a few cycles, as a pending flag that fails to clear or a grant that repeats one time too many or too few. A wrong round-robin pointer or queue decision shows on the first grant after the arbitration cycle, as a grant to the wrong channel. A bad enable update shows on hw_en_o or sw_en_o one cycle after the strobe, or as a channel that is never granted. Random trigger masks in both modes are compared against an order the bench computes from the last grant it observed at the ports.

// File: rtl/dma_arb_pkg.sv
// Package: shared encodings for the DMA request arbiter.
// Assumes nothing beyond a standard 1800-2017 tool.
package dma_arb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Origin of one buffered trigger
    typedef enum logic {
        SRC_HW = 1'b0,
        SRC_SW = 1'b1
    } trig_src_e;
endpackage

// File: rtl/dma_arb_slot.sv
// Module: per-channel trigger buffer and enable register.
// It stores up to DEPTH triggers in arrival order, each tagged hardware or
// software. On a pop it drops the oldest trigger first, then appends this
// cycle's hardware request and then this cycle's software trigger.
// Assumes pop_i and blk_done_i are asserted only for the granted channel.
module dma_arb_slot
    import dma_arb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req_i,
    input  logic sw_trig_i,
    input  logic hw_en_set_i,
    input  logic hw_en_clr_i,
    input  logic sw_en_set_i,
    input  logic sw_en_clr_i,
    input  logic pop_i,
    input  logic blk_done_i,
    output logic pending_o,
    output logic eligible_o,
    output logic head_sw_o,
    output logic hw_en_o,
    output logic sw_en_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0]    cnt_q, cnt_n;
    logic [DEPTH-1:0] src_q, src_n;
    logic             hw_en_q, sw_en_q;

    // Next buffer state: pop first, then append the hardware and software triggers
    always_comb begin
        cnt_n = cnt_q;
        src_n = src_q;
        if (pop_i && cnt_q != '0) begin
            src_n = src_q >> 1;
            cnt_n = cnt_q - CW'(1);
        end
        if (hw_req_i && cnt_n < DEPTH_C) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_n == CW'(i)) src_n[i] = SRC_HW;
            end
            cnt_n = cnt_n + CW'(1);
        end
        if (sw_trig_i && sw_en_q && cnt_n < DEPTH_C) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_n == CW'(i)) src_n[i] = SRC_SW;
            end
            cnt_n = cnt_n + CW'(1);
        end
    end

    // Buffer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            src_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            src_q <= src_n;
        end
    end

    // Enable registers: a clear strobe or block completion wins over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_en_q <= 1'b0;
            sw_en_q <= 1'b0;
        end else begin
            hw_en_q <= (hw_en_q | hw_en_set_i) & ~hw_en_clr_i & ~blk_done_i;
            sw_en_q <= (sw_en_q | sw_en_set_i) & ~sw_en_clr_i;
        end
    end

    assign pending_o  = (cnt_q != '0);
    assign head_sw_o  = src_q[0];
    assign eligible_o = pending_o && (src_q[0] == SRC_SW || hw_en_q);
    assign hw_en_o    = hw_en_q;
    assign sw_en_o    = sw_en_q;

    // R6: the buffer never holds more than DEPTH triggers
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);

    // R7: a hardware request on an empty buffer is captured whatever the enable
    a_r7_hw_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req_i && cnt_q == '0) |=> pending_o);

    // R8: block completion leaves the hardware enable clear
    a_r8_hw_en_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_i |=> !hw_en_o);

    // R11: a software trigger alone is ignored while the software enable is clear
    a_r11_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig_i && !sw_en_q && !hw_req_i && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_arb_pick.sv
// Module: picks one requester out of a mask.
// With rr_i low it returns the lowest set index. With rr_i high the search
// starts at last_i + 1 and wraps. Purely combinational.
module dma_arb_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         req_i,
    input  logic [$clog2(N)-1:0] last_i,
    input  logic                 rr_i,
    output logic                 found_o,
    output logic [$clog2(N)-1:0] idx_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW = $clog2(N);

    // Scan from the far end so that the first position in search order wins
    always_comb begin
        int j;
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            j = rr_i ? (int'(last_i) + 1 + k) % N : k;
            if (req_i[j]) begin
                found_o = 1'b1;
                idx_o   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// Module: DMA request arbiter, top level.
// It collects triggers per channel, chooses the high or low queue, and holds
// a one-hot grant until the engine's done strobe ends the unit of work.
// There is always one idle cycle between grants.
// Assumes frame_done_i and block_done_i refer to the granted channel.
module dma_req_arbiter #(
    parameter int NUM_CH     = 16,
    parameter int TRIG_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hw_req_i,
    input  logic [NUM_CH-1:0] sw_trig_i,
    input  logic [NUM_CH-1:0] hw_en_set_i,
    input  logic [NUM_CH-1:0] hw_en_clr_i,
    input  logic [NUM_CH-1:0] sw_en_set_i,
    input  logic [NUM_CH-1:0] sw_en_clr_i,
    input  logic [NUM_CH-1:0] hiq_sel_i,
    input  logic              rr_mode_i,
    input  logic [NUM_CH-1:0] auto_init_i,
    input  logic [NUM_CH-1:0] frame_trig_i,
    input  logic              frame_done_i,
    input  logic              block_done_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              grant_valid_o,
    output logic [NUM_CH-1:0] pending_o,
    output logic [NUM_CH-1:0] hw_en_o,
    output logic [NUM_CH-1:0] sw_en_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW = $clog2(NUM_CH);
    localparam logic [IW-1:0] LAST_RST = IW'(NUM_CH - 1);

    logic [NUM_CH-1:0] elig, head_sw, pop, blk;
    logic [NUM_CH-1:0] hi_req, lo_req;
    logic              hi_found, lo_found;
    logic [IW-1:0]     hi_idx, lo_idx;
    logic              busy_q;
    logic [IW-1:0]     gidx_q, last_hi_q, last_lo_q;
    logic              unit_end, retrig;

    // Unit end and auto-initiation decisions for the held grant
    assign unit_end = busy_q && (block_done_i || (frame_done_i && frame_trig_i[gidx_q]));
    assign retrig   = block_done_i && auto_init_i[gidx_q] && head_sw[gidx_q];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign pop[c] = unit_end && (gidx_q == IW'(c)) && !retrig;
        assign blk[c] = busy_q && block_done_i && (gidx_q == IW'(c));

        dma_arb_slot #(.DEPTH(TRIG_DEPTH)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .hw_req_i    (hw_req_i[c]),
            .sw_trig_i   (sw_trig_i[c]),
            .hw_en_set_i (hw_en_set_i[c]),
            .hw_en_clr_i (hw_en_clr_i[c]),
            .sw_en_set_i (sw_en_set_i[c]),
            .sw_en_clr_i (sw_en_clr_i[c]),
            .pop_i       (pop[c]),
            .blk_done_i  (blk[c]),
            .pending_o   (pending_o[c]),
            .eligible_o  (elig[c]),
            .head_sw_o   (head_sw[c]),
            .hw_en_o     (hw_en_o[c]),
            .sw_en_o     (sw_en_o[c])
        );
    end

    assign hi_req = elig & hiq_sel_i;
    assign lo_req = elig & ~hiq_sel_i;

    dma_arb_pick #(.N(NUM_CH)) pick_hi_i (
        .req_i   (hi_req),
        .last_i  (last_hi_q),
        .rr_i    (rr_mode_i),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    dma_arb_pick #(.N(NUM_CH)) pick_lo_i (
        .req_i   (lo_req),
        .last_i  (last_lo_q),
        .rr_i    (rr_mode_i),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    // Grant sequencing: hold until the unit ends, otherwise grant from the high queue first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            gidx_q    <= '0;
            last_hi_q <= LAST_RST;
            last_lo_q <= LAST_RST;
        end else if (busy_q) begin
            if (unit_end) busy_q <= 1'b0;
        end else if (hi_found) begin
            busy_q    <= 1'b1;
            gidx_q    <= hi_idx;
            last_hi_q <= hi_idx;
        end else if (lo_found) begin
            busy_q    <= 1'b1;
            gidx_q    <= lo_idx;
            last_lo_q <= lo_idx;
        end
    end

    // One-hot decode of the held channel
    always_comb begin
        grant_o = '0;
        if (busy_q) grant_o[gidx_q] = 1'b1;
    end

    assign grant_valid_o = busy_q;

    // R2: grant is one-hot or zero and matches valid
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

    // R2: with nothing eligible and no grant held, the block stays idle
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && elig == '0) |=> !grant_valid_o);

    // R10: the grant does not move before the unit of work ends
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !unit_end) |=> (busy_q && $stable(gidx_q)));

    // R4: an eligible high-queue channel takes the next grant
    a_r4_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && hi_req != '0) |=> ((grant_o & $past(hiq_sel_i)) != '0));

    // R3: fixed priority in the low queue grants the lowest eligible channel
    a_r3_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !rr_mode_i && hi_req == '0 && lo_req != '0)
            |=> (grant_o == ($past(lo_req) & (~$past(lo_req) + 1'b1))));
endmodule

// File: tb/dma_req_arbiter_tb_top.sv
// Bench: directed corner cases followed by seeded random masks, checked at the ports.
module dma_req_arbiter_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  hw_req = '0, sw_trig = '0;
    logic [NCH-1:0]  hw_en_set = '0, hw_en_clr = '0, sw_en_set = '0, sw_en_clr = '0;
    logic [NCH-1:0]  hiq_sel = '0, auto_init = '0, frame_trig = '0;
    logic            rr_mode = 1'b0, frame_done = 1'b0, block_done = 1'b0;
    logic [NCH-1:0]  grant, pending, hw_en, sw_en;
    logic            grant_valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int last_lo_mon = NCH - 1;
    bit vprev = 1'b0;

    dma_req_arbiter #(.NUM_CH(NCH), .TRIG_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hw_req_i(hw_req), .sw_trig_i(sw_trig),
        .hw_en_set_i(hw_en_set), .hw_en_clr_i(hw_en_clr),
        .sw_en_set_i(sw_en_set), .sw_en_clr_i(sw_en_clr),
        .hiq_sel_i(hiq_sel), .rr_mode_i(rr_mode),
        .auto_init_i(auto_init), .frame_trig_i(frame_trig),
        .frame_done_i(frame_done), .block_done_i(block_done),
        .grant_o(grant), .grant_valid_o(grant_valid),
        .pending_o(pending), .hw_en_o(hw_en), .sw_en_o(sw_en)
    );

    always #2.5 clk = ~clk;

    function automatic int oh_idx(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int rr_pick(input logic [NCH-1:0] m, input int last);
        for (int k = 1; k <= NCH; k++) if (m[(last + k) % NCH]) return (last + k) % NCH;
        return -1;
    endfunction

    function automatic int low_pick(input logic [NCH-1:0] m);
        return oh_idx(m);
    endfunction

    // Record the low-queue channel of each new grant, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && grant_valid && !vprev && (grant & ~hiq_sel) != '0)
            last_lo_mon = oh_idx(grant);
        vprev = grant_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_trig(input logic [NCH-1:0] hw, input logic [NCH-1:0] sw);
        hw_req = hw; sw_trig = sw;
        tick();
        hw_req = '0; sw_trig = '0;
    endtask

    task automatic pulse_en(input logic [NCH-1:0] hs, input logic [NCH-1:0] hc,
                            input logic [NCH-1:0] ss, input logic [NCH-1:0] sc);
        hw_en_set = hs; hw_en_clr = hc; sw_en_set = ss; sw_en_clr = sc;
        tick();
        hw_en_set = '0; hw_en_clr = '0; sw_en_set = '0; sw_en_clr = '0;
    endtask

    task automatic end_block();
        block_done = 1'b1;
        tick();
        block_done = 1'b0;
        tick();
    endtask

    task automatic end_frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] prev, mask, rem;
        int exp, lastexp, g0;
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 grant", 32'(grant), 0);
        check("R1 valid", 32'(grant_valid), 0);
        check("R1 pending", 32'(pending), 0);
        check("R1 enables", 32'({hw_en, sw_en}), 0);

        // R7 capture with hardware enable clear, served after the enable is set
        pulse_trig(16'h0020, '0);
        check("R7 pending while disabled", 32'(pending), 32'h0020);
        tick(); tick();
        check("R7 not granted while disabled", 32'(grant_valid), 0);
        pulse_en(16'h0020, '0, '0, '0);
        tick();
        check("R7 granted after enable", 32'(grant), 32'h0020);
        end_block();
        check("R8 hw enable cleared at block end", 32'(hw_en[5]), 0);
        check("R6 trigger consumed", 32'(pending), 0);
        check("R2 idle after drain", 32'({grant_valid, grant}), 0);

        // R6 two-deep buffer with frame-triggered channel
        frame_trig = 16'h0004;
        pulse_trig(16'h0004, '0); pulse_trig(16'h0004, '0); pulse_trig(16'h0004, '0);
        pulse_en(16'h0004, '0, '0, '0);
        tick();
        check("R6 first grant", 32'(grant), 32'h0004);
        end_frame();
        check("R6 second grant", 32'(grant), 32'h0004);
        check("R10 frame end keeps hw enable", 32'(hw_en[2]), 1);
        end_frame();
        check("R6 third trigger dropped", 32'({grant_valid, pending}), 0);
        frame_trig = '0;
        pulse_en('0, 16'h0004, '0, '0);

        // R10 frame_done ignored for a block-triggered channel
        pulse_en('0, '0, 16'h0100, '0);
        pulse_trig('0, 16'h0100);
        tick();
        check("R10 granted", 32'(grant), 32'h0100);
        end_frame();
        check("R10 grant held over frame_done", 32'({grant_valid, grant}), 32'h10100);
        end_block();
        check("R10 released by block_done", 32'(grant_valid), 0);

        // R3 fixed priority order
        pulse_en('0, '0, 16'h4208, '0);
        pulse_trig('0, 16'h4208);
        tick();
        check("R3 first", 32'(grant), 32'h0008);
        end_block();
        check("R3 second", 32'(grant), 32'h0200);
        end_block();
        check("R3 third", 32'(grant), 32'h4000);
        end_block();
        check("R3 drained", 32'(grant_valid), 0);

        // R4 high queue first
        hiq_sel = 16'h1000;
        pulse_en('0, '0, 16'h1002, '0);
        pulse_trig('0, 16'h1002);
        tick();
        check("R4 high queue wins", 32'(grant), 32'h1000);
        end_block();
        check("R4 low queue after", 32'(grant), 32'h0002);
        end_block();
        hiq_sel = '0;

        // R9 auto-initiation starves a lower channel under fixed priority
        pulse_en('0, '0, 16'h0081, '0);
        auto_init = 16'h0001;
        pulse_trig('0, 16'h0081);
        tick();
        check("R9 first grant", 32'(grant), 32'h0001);
        for (int i = 0; i < 3; i++) begin
            end_block();
            check("R9 retriggered", 32'(grant), 32'h0001);
        end
        check("R9 still pending", 32'(pending), 32'h0081);
        auto_init = '0;
        end_block();
        check("R9 lower channel after auto-init off", 32'(grant), 32'h0080);
        end_block();

        // R5 round-robin alternates two auto-initiating channels
        rr_mode = 1'b1;
        pulse_en('0, '0, 16'h0024, '0);
        auto_init = 16'h0024;
        lastexp = last_lo_mon;
        pulse_trig('0, 16'h0024);
        tick();
        for (int i = 0; i < 4; i++) begin
            exp = rr_pick(16'h0024, lastexp);
            check("R5 round-robin turn", 32'(grant), 32'(1) << exp);
            lastexp = exp;
            end_block();
        end
        auto_init = '0;
        for (int i = 0; i < 4; i++) if (grant_valid) end_block();
        check("R5 drained", 32'({grant_valid, pending}), 0);
        rr_mode = 1'b0;

        // R11 software trigger ignored when software enable is clear
        pulse_trig('0, 16'h0010);
        check("R11 not pending", 32'(pending), 0);
        tick();
        check("R11 no grant", 32'(grant_valid), 0);

        // R12 per-channel set and clear, clear wins
        prev = sw_en;
        pulse_en(16'h0400, 16'h0400, 16'h00C0, 16'h0080);
        check("R12 sw enables", 32'(sw_en), 32'((prev | 16'h0040) & ~16'h0080));
        check("R12 hw clear wins", 32'(hw_en), 0);

        // Random masks in both modes
        pulse_en('0, '0, 16'hFFFF, '0);
        for (int r = 0; r < 24; r++) begin
            rr_mode = 1'($urandom % 2);
            mask = 16'($urandom);
            if (mask == '0) mask = 16'h0001;
            lastexp = last_lo_mon;
            pulse_trig('0, mask);
            tick();
            rem = mask;
            while (rem != '0) begin
                exp = rr_mode ? rr_pick(rem, lastexp) : low_pick(rem);
                check(rr_mode ? "R5 random order" : "R3 random order", 32'(grant), 32'(1) << exp);
                rem[exp] = 1'b0;
                lastexp = exp;
                end_block();
            end
            g0 = 0;
            check("R2 random idle", 32'({grant_valid, pending}), 32'(g0));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule